// File: doc/BRIEF.md
# Grouped Interrupt Router

This block collects 64 level interrupt sources and steers them onto 16 output interrupt lines. Each source is first corrected for polarity, so that every line becomes active-high inside the block. It is then gated by a per-source enable, and may also be forced by a software trigger bit. A source that passes these stages sets a sticky, active-high status bit. Software clears a status bit by writing 1 to it.

Every output line belongs to a group. A group is a 64-bit membership mask, and the line is the registered OR of the status bits that are members of that group. Groups may overlap, so one source can raise several outputs at once. Software can read each group's masked status to find which member raised its line.

Software reaches all state through a plain 32-bit register port with one address bus. A write takes effect on the clock edge where `reg_wr_en` is high. A read is combinational from `reg_addr`. There is no back-pressure on this port: it accepts one access per clock and never stalls. Every 64-bit vector is a pair of words at consecutive word addresses, with the low word (sources 0 to 31) first. Address bits 1:0 are ignored.

Top module: `grp_irq_router`

## Requirements
- R1: After reset, the following are all zero: status, enable, wake enable, stage-1 enable, software trigger, every group mask and every output line. Polarity resets to all ones, so every source starts active-low.
- R2: The pin pair at byte offsets 0x00 (low word) and 0x04 (high word) returns the current, unlatched `irq_pin` value in the same cycle.
- R3: A source is active when its pin differs from its polarity bit. With polarity 1 the source is active on a low pin; with polarity 0 it is active on a high pin.
- R4: A status bit sets on a clock edge where its enable bit is 1 and either the source is active or its software trigger bit is 1. A source whose enable bit is 0 never sets its status bit.
- R5: The status pair is at 0x08/0x0C and is write-1-to-clear. A clear does not take effect while the source is still active, because setting wins over clearing.
- R6: Output line g is high exactly one clock after (status AND group mask g) becomes non-zero, and low one clock after it becomes zero.
- R7: A source that is a member of several groups raises every one of their output lines.
- R8: The group status pair for group g sits at 0xC0+8g (low word) and 0xC4+8g (high word). It returns status AND group mask g.
- R9: The reserved pair at 0x28/0x2C and every unmapped address read zero, and writes to them change nothing. Writes to the pin pair and to the group status pairs are also ignored.
- R10: The following pairs read back what was last written: enable at 0x10, polarity at 0x18, wake enable at 0x20, stage-1 enable at 0x30, software trigger at 0x38, and group mask g at 0x40+8g.
- R11: Wake enable and stage-1 enable are storage only. Setting them does not set status bits or raise outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 64 | Interrupt source pins, already synchronous to clk, idle high |
| reg_addr | input | 9 | Byte address shared by reads and writes |
| reg_wr_en | input | 1 | Write strobe for the addressed word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| grp_irq | output | 16 | Registered group output lines |

## Verification
The assertions assume that `irq_pin` and the register port are synchronous to `clk` and stable around each rising edge. They also assume that reset is held low across at least one edge before operation starts. The stimulus changes every input one time unit after a falling edge and holds reset low for several cycles. It mixes directed sequences, which cover the clear-while-active, overlap and polarity cases, with random word writes and random pin toggles. Random addresses include the reserved, read-only and unmapped regions, so those stay exercised.

// File: rtl/intc_grp_pkg.sv
package intc_grp_pkg;
  localparam int unsigned IC_NUM_IN  = 64;
  localparam int unsigned IC_NUM_GRP = 16;
  localparam int unsigned IC_DW      = 32;
  localparam int unsigned IC_AW      = 9;
  localparam int unsigned IC_CTRL_PAIRS = 8;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_MASK  = 2'd1,
    RG_GSTAT = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    PR_PIN  = 3'd0,
    PR_STAT = 3'd1,
    PR_EN   = 3'd2,
    PR_POL  = 3'd3,
    PR_WAKE = 3'd4,
    PR_RSVD = 3'd5,
    PR_STG1 = 3'd6,
    PR_SWT  = 3'd7
  } pair_e;
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_grp_pkg::*;
#(
  parameter int unsigned AW      = IC_AW,
  parameter int unsigned NUM_GRP = IC_NUM_GRP,
  localparam int unsigned GW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned PW     = AW - 3
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output pair_e         pair_o,
  output logic [GW-1:0] grp_o,
  output logic          hi_o
);
  localparam int unsigned MASK_END  = IC_CTRL_PAIRS + NUM_GRP;
  localparam int unsigned GSTAT_END = IC_CTRL_PAIRS + 2 * NUM_GRP;

  logic [PW-1:0] pair_idx;
  int unsigned   pidx;

  assign pair_idx = addr_i[AW-1:3];
  assign hi_o     = addr_i[2];
  assign pidx     = int'(pair_idx);

  always_comb begin
    region_o = RG_NONE;
    pair_o   = PR_RSVD;
    grp_o    = '0;
    if (pidx < IC_CTRL_PAIRS) begin
      region_o = RG_CTRL;
      pair_o   = pair_e'(pair_idx[2:0]);
    end else if (pidx < MASK_END) begin
      region_o = RG_MASK;
      grp_o    = GW'(pidx - IC_CTRL_PAIRS);
    end else if (pidx < GSTAT_END) begin
      region_o = RG_GSTAT;
      grp_o    = GW'(pidx - MASK_END);
    end
  end
endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
  import intc_grp_pkg::*;
#(
  parameter int unsigned NUM_IN  = IC_NUM_IN,
  parameter int unsigned NUM_GRP = IC_NUM_GRP,
  parameter int unsigned DW      = IC_DW,
  localparam int unsigned GW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned WORDS  = NUM_IN / DW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  region_e                        region_i,
  input  pair_e                          pair_i,
  input  logic [GW-1:0]                  grp_i,
  input  logic                           hi_i,
  input  logic [DW-1:0]                  wr_data_i,
  output logic [NUM_IN-1:0]              en_q,
  output logic [NUM_IN-1:0]              pol_q,
  output logic [NUM_IN-1:0]              wake_q,
  output logic [NUM_IN-1:0]              stg1_q,
  output logic [NUM_IN-1:0]              swt_q,
  output logic [NUM_GRP-1:0][NUM_IN-1:0] mask_q,
  output logic [NUM_IN-1:0]              stat_clr_o
);
  logic [NUM_IN-1:0] lane_msk;
  logic [NUM_IN-1:0] lane_dat;
  logic              ctrl_wr;

  always_comb begin
    lane_msk = '0;
    lane_msk[int'(hi_i) * DW +: DW] = '1;
  end
  assign lane_dat = {WORDS{wr_data_i}};
  assign ctrl_wr  = wr_en_i && (region_i == RG_CTRL);
  assign stat_clr_o = (ctrl_wr && pair_i == PR_STAT) ? (lane_dat & lane_msk) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      wake_q <= '0;
      stg1_q <= '0;
      swt_q  <= '0;
    end else if (ctrl_wr) begin
      unique case (pair_i)
        PR_EN:   en_q   <= (en_q   & ~lane_msk) | (lane_dat & lane_msk);
        PR_POL:  pol_q  <= (pol_q  & ~lane_msk) | (lane_dat & lane_msk);
        PR_WAKE: wake_q <= (wake_q & ~lane_msk) | (lane_dat & lane_msk);
        PR_STG1: stg1_q <= (stg1_q & ~lane_msk) | (lane_dat & lane_msk);
        PR_SWT:  swt_q  <= (swt_q  & ~lane_msk) | (lane_dat & lane_msk);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '0;
      end else if (wr_en_i && region_i == RG_MASK && grp_i == GW'(g)) begin
        mask_q[g] <= (mask_q[g] & ~lane_msk) | (lane_dat & lane_msk);
      end
    end
  end

  // R1: every control vector comes out of reset in its defined state
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (en_q == '0 && pol_q == '1 && swt_q == '0 && mask_q == '0));

  // R9: a write into the group status region leaves masks and enables alone
  p_gstat_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && region_i == RG_GSTAT) |=> ($stable(mask_q) && $stable(en_q)));
endmodule

// File: rtl/intc_status_latch.sv
module intc_status_latch
  import intc_grp_pkg::*;
#(
  parameter int unsigned NUM_IN = IC_NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin_i,
  input  logic [NUM_IN-1:0] pol_i,
  input  logic [NUM_IN-1:0] en_i,
  input  logic [NUM_IN-1:0] swt_i,
  input  logic [NUM_IN-1:0] clr_i,
  output logic [NUM_IN-1:0] stat_q
);
  logic [NUM_IN-1:0] active;
  logic [NUM_IN-1:0] set_vec;

  assign active  = pin_i ^ pol_i;
  assign set_vec = (active | swt_i) & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | set_vec;
  end

  // R4: a status bit can only rise where the enable was set on the previous edge
  p_set_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~$past(en_i)) == '0);

  // R5: a set status bit only drops after a clear strobe on that bit
  p_hold_until_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q) & $past(stat_q) & ~$past(clr_i)) == '0);
endmodule

// File: rtl/intc_group_route.sv
module intc_group_route
  import intc_grp_pkg::*;
#(
  parameter int unsigned NUM_IN  = IC_NUM_IN,
  parameter int unsigned NUM_GRP = IC_NUM_GRP
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IN-1:0]              stat_i,
  input  logic [NUM_GRP-1:0][NUM_IN-1:0] mask_i,
  output logic [NUM_GRP-1:0]             grp_q
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[g] <= 1'b0;
      else        grp_q[g] <= |(stat_i & mask_i[g]);
    end

    // R6: a line rises only after a member status bit was seen set
    p_rise_has_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_q[g]) |-> $past(|(stat_i & mask_i[g])));

    // R6: a line falls only after no member status bit was set
    p_fall_no_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grp_q[g]) |-> $past((stat_i & mask_i[g]) == '0));
  end
endmodule

// File: rtl/grp_irq_router.sv
module grp_irq_router
  import intc_grp_pkg::*;
#(
  parameter int unsigned NUM_IN  = IC_NUM_IN,
  parameter int unsigned NUM_GRP = IC_NUM_GRP,
  parameter int unsigned AW      = IC_AW,
  parameter int unsigned DW      = IC_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  irq_pin,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr_en,
  input  logic [DW-1:0]      reg_wr_data,
  output logic [DW-1:0]      reg_rd_data,
  output logic [NUM_GRP-1:0] grp_irq
);
  localparam int unsigned GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  region_e       dec_region;
  pair_e         dec_pair;
  logic [GW-1:0] dec_grp;
  logic          dec_hi;

  logic [NUM_IN-1:0]              en_q, pol_q, wake_q, stg1_q, swt_q;
  logic [NUM_GRP-1:0][NUM_IN-1:0] mask_q;
  logic [NUM_IN-1:0]              stat_clr;
  logic [NUM_IN-1:0]              stat_q;
  logic [NUM_IN-1:0]              rd_vec;

  intc_addr_dec #(.AW(AW), .NUM_GRP(NUM_GRP)) u_dec (
    .addr_i   (reg_addr),
    .region_o (dec_region),
    .pair_o   (dec_pair),
    .grp_o    (dec_grp),
    .hi_o     (dec_hi)
  );

  intc_ctrl_regs #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr_en),
    .region_i   (dec_region),
    .pair_i     (dec_pair),
    .grp_i      (dec_grp),
    .hi_i       (dec_hi),
    .wr_data_i  (reg_wr_data),
    .en_q       (en_q),
    .pol_q      (pol_q),
    .wake_q     (wake_q),
    .stg1_q     (stg1_q),
    .swt_q      (swt_q),
    .mask_q     (mask_q),
    .stat_clr_o (stat_clr)
  );

  intc_status_latch #(.NUM_IN(NUM_IN)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (irq_pin),
    .pol_i  (pol_q),
    .en_i   (en_q),
    .swt_i  (swt_q),
    .clr_i  (stat_clr),
    .stat_q (stat_q)
  );

  intc_group_route #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_q),
    .mask_i (mask_q),
    .grp_q  (grp_irq)
  );

  always_comb begin
    rd_vec = '0;
    unique case (dec_region)
      RG_CTRL: begin
        unique case (dec_pair)
          PR_PIN:  rd_vec = irq_pin;
          PR_STAT: rd_vec = stat_q;
          PR_EN:   rd_vec = en_q;
          PR_POL:  rd_vec = pol_q;
          PR_WAKE: rd_vec = wake_q;
          PR_STG1: rd_vec = stg1_q;
          PR_SWT:  rd_vec = swt_q;
          default: rd_vec = '0;
        endcase
      end
      RG_MASK:  rd_vec = mask_q[dec_grp];
      RG_GSTAT: rd_vec = stat_q & mask_q[dec_grp];
      default:  rd_vec = '0;
    endcase
  end

  assign reg_rd_data = rd_vec[int'(dec_hi) * DW +: DW];

  // R9: the reserved pair never returns data
  p_rsvd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_region == RG_CTRL && dec_pair == PR_RSVD) |-> (reg_rd_data == '0));
endmodule

// File: tb/grp_irq_router_tb_top.sv
module grp_irq_router_tb_top;
  localparam int CLK_HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_pin = '1;
  logic [8:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [15:0] grp_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk = ~clk;

  grp_irq_router dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin     (irq_pin),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .grp_irq     (grp_irq)
  );

  // behavioural reference
  logic [63:0] m_en, m_pol, m_wake, m_stg, m_swt, m_stat;
  logic [63:0] m_mask [16];
  logic [15:0] m_grp;

  function automatic logic [63:0] put_word(logic [63:0] old, bit hi, logic [31:0] d);
    logic [63:0] r = old;
    if (hi) r[63:32] = d; else r[31:0] = d;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= '0; m_pol <= '1; m_wake <= '0; m_stg <= '0; m_swt <= '0; m_stat <= '0;
      m_grp <= '0;
      for (int g = 0; g < 16; g++) m_mask[g] <= '0;
    end else begin
      int w;
      int pr;
      bit hi;
      logic [63:0] clr;
      logic [63:0] setv;
      w   = int'(reg_addr) / 4;
      pr  = w / 2;
      hi  = w[0];
      clr = '0;
      setv = ((irq_pin ^ m_pol) | m_swt) & m_en;
      for (int g = 0; g < 16; g++) m_grp[g] <= |(m_stat & m_mask[g]);
      if (reg_wr_en) begin
        case (pr)
          1: clr = put_word('0, hi, reg_wr_data);
          2: m_en   <= put_word(m_en, hi, reg_wr_data);
          3: m_pol  <= put_word(m_pol, hi, reg_wr_data);
          4: m_wake <= put_word(m_wake, hi, reg_wr_data);
          6: m_stg  <= put_word(m_stg, hi, reg_wr_data);
          7: m_swt  <= put_word(m_swt, hi, reg_wr_data);
          default: if (pr >= 8 && pr < 24) m_mask[pr-8] <= put_word(m_mask[pr-8], hi, reg_wr_data);
        endcase
      end
      m_stat <= (m_stat & ~clr) | setv;
    end
  end

  function automatic logic [31:0] exp_rd(logic [8:0] a);
    int w = int'(a) / 4;
    int pr = w / 2;
    logic [63:0] v;
    case (pr)
      0: v = irq_pin;
      1: v = m_stat;
      2: v = m_en;
      3: v = m_pol;
      4: v = m_wake;
      6: v = m_stg;
      7: v = m_swt;
      default: begin
        if (pr >= 8 && pr < 24) v = m_mask[pr-8];
        else if (pr >= 24 && pr < 40) v = m_stat & m_mask[pr-24];
        else v = '0;
      end
    endcase
    return w[0] ? v[63:32] : v[31:0];
  endfunction

  function automatic string tag_of(logic [8:0] a);
    int pr = int'(a) / 8;
    if (pr == 0) return "R2";
    if (pr == 1) return "R5";
    if (pr == 5 || pr >= 40) return "R9";
    if (pr >= 24) return "R8";
    return "R10";
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk += 2;
      if (reg_rd_data !== exp_rd(reg_addr)) begin
        n_fail++;
        $display("FAIL %s read addr=%h actual=%h expected=%h", tag_of(reg_addr),
                 reg_addr, reg_rd_data, exp_rd(reg_addr));
      end
      if (grp_irq !== m_grp) begin
        n_fail++;
        $display("FAIL R6 group lines actual=%h expected=%h", grp_irq, m_grp);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic chk(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    n_chk++;
    if (reg_rd_data !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rd_data, e);
    end
  endtask

  task automatic chk_grp(input logic [15:0] e, input string tag);
    @(negedge clk);
    n_chk++;
    if (grp_irq !== e) begin
      n_fail++;
      $display("FAIL %s grp_irq actual=%h expected=%h", tag, grp_irq, e);
    end
  endtask

  task automatic pins(input logic [63:0] v);
    @(negedge clk); #1;
    irq_pin = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(9'h018, 32'hFFFF_FFFF, "R1");
    chk(9'h01C, 32'hFFFF_FFFF, "R1");
    chk(9'h010, 32'h0, "R1");
    chk(9'h040, 32'h0, "R1");
    chk(9'h008, 32'h0, "R1");
    chk_grp(16'h0, "R1");
    // R2 raw pins
    pins({32'hFFFF_FFFF, 32'h1234_5678});
    chk(9'h000, 32'h1234_5678, "R2");
    chk(9'h004, 32'hFFFF_FFFF, "R2");
    chk(9'h008, 32'h0, "R4");
    pins('1);
    // R10 masks and enables
    wr(9'h040, 32'h1);
    wr(9'h048, 32'h3);
    wr(9'h0BC, 32'h8000_0000);
    chk(9'h048, 32'h3, "R10");
    chk(9'h0BC, 32'h8000_0000, "R10");
    wr(9'h010, 32'h3);
    wr(9'h014, 32'h8000_0000);
    chk(9'h014, 32'h8000_0000, "R10");
    // R4 / R7 / R8: input 0 active low, member of groups 0 and 1
    pins(64'hFFFF_FFFF_FFFF_FFFE);
    chk(9'h008, 32'h1, "R4");
    chk_grp(16'h0003, "R7");
    chk(9'h0C8, 32'h1, "R8");
    chk(9'h0D0, 32'h0, "R8");
    // R5 clear while active has no effect, then clear after release
    wr(9'h008, 32'h1);
    chk(9'h008, 32'h1, "R5");
    pins('1);
    wr(9'h008, 32'h1);
    chk(9'h008, 32'h0, "R5");
    chk_grp(16'h0, "R6");
    // R3 polarity: input 63 active high
    wr(9'h01C, 32'h7FFF_FFFF);
    chk(9'h00C, 32'h8000_0000, "R3");
    chk_grp(16'h8000, "R6");
    pins(64'h7FFF_FFFF_FFFF_FFFF);
    wr(9'h00C, 32'h8000_0000);
    chk(9'h00C, 32'h0, "R3");
    // R4 software trigger on input 1
    wr(9'h038, 32'h2);
    chk(9'h008, 32'h2, "R4");
    chk_grp(16'h0002, "R6");
    wr(9'h038, 32'h0);
    wr(9'h008, 32'h2);
    chk(9'h008, 32'h0, "R4");
    // R4 disabled input 2 never sets
    pins(64'h7FFF_FFFF_FFFF_FFFB);
    chk(9'h008, 32'h0, "R4");
    pins(64'h7FFF_FFFF_FFFF_FFFF);
    // R11 wake and stage-1 enable are storage only
    wr(9'h020, 32'h20);
    wr(9'h030, 32'h20);
    pins(64'h7FFF_FFFF_FFFF_FFDF);
    chk(9'h020, 32'h20, "R10");
    chk(9'h030, 32'h20, "R10");
    chk(9'h008, 32'h0, "R11");
    chk_grp(16'h0, "R11");
    pins(64'h7FFF_FFFF_FFFF_FFFF);
    // R9 reserved and read-only regions
    wr(9'h028, 32'hFFFF_FFFF);
    chk(9'h028, 32'h0, "R9");
    chk(9'h02C, 32'h0, "R9");
    wr(9'h0C0, 32'hFFFF_FFFF);
    chk(9'h040, 32'h1, "R9");
    wr(9'h000, 32'h0);
    chk(9'h000, 32'hFFFF_FFFF, "R9");
    wr(9'h1F0, 32'hFFFF_FFFF);
    chk(9'h1F0, 32'h0, "R9");
    // random phase, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(3, 0) == 0) irq_pin[$urandom_range(63, 0)] ^= 1'b1;
      reg_wr_en   = ($urandom_range(2, 0) == 0);
      reg_addr    = 9'($urandom_range(85, 0) * 4);
      reg_wr_data = $urandom;
    end
    @(negedge clk); #1 reg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule